// File: doc/BRIEF.md
# Dual-Port Parallel I/O Controller

This block is a peripheral with two 8-bit parallel ports, A and B, that sits on an 8-bit processor I/O bus. It decodes each bus cycle from chip-enable, I/O-request, read, M1, port-select and control/data-select inputs into a control read, control write, data read or data write. The cycle is directed at one of the two ports. Each port keeps its own mode, output register, bit-control direction mask, interrupt vector and interrupt-enable flag.

A control write programs the selected port. It can set one of four modes, load the interrupt vector, or, right after bit-control mode is chosen, load the direction mask. The pin drive follows the mode. Output mode puts the output register on the pins. Input and bidirectional modes hold every pin high so that an external source can pull it down. Bit-control mode mixes the two per bit. The processor data bus is split into an input byte and a registered output byte with an enable. Handshake strobes and the interrupt daisy chain sit outside this block, which only supplies the vectors and enable flags to that logic.

Top module: `pio_dual_port`

## Requirements
- R1: After reset both ports are in input mode, both pin outputs read 0xFF, both interrupt-enable flags are 0, both vectors are 0x00 and data_oe_o is 0.
- R2: port_sel_i = 1 directs a cycle at port B and port_sel_i = 0 directs it at port A. The port not selected is left unchanged.
- R3: A control write with no mask pending and data bits 3:0 = 4'hF loads the mode from data bits 7:6. The encodings are 00 output, 01 input, 10 bidirectional and 11 bit-control.
- R4: A control write with no mask pending and data bit 0 = 0 loads the byte as the port's interrupt vector and sets its interrupt-enable flag to 1.
- R5: A data write (cd_sel_i = 0, rd_i = 0) stores the byte in the selected port's output register. In output mode the pins show it after the write edge.
- R6: In input and bidirectional modes the port pins are driven as 0xFF, whatever the output register holds.
- R7: In bit-control mode, pin bit i is 1 where mask bit i is 1. Where mask bit i is 0, pin bit i is output register bit i.
- R8: A cycle with ce_i = 0, iorq_i = 0 or m1_i = 1 changes no register and does not set data_oe_o.
- R9: The control write right after a bit-control mode word is taken as the direction mask, whatever its value. The control write after that is decoded normally again.
- R10: A data read loads data_o with the selected port's pin inputs as sampled on the read edge. It sets data_oe_o for the following cycle.
- R11: A control read returns {mode[1:0], 5'b00000, interrupt-enable} of the selected port on data_o, with data_oe_o set.
- R12: A control write with no mask pending, data bit 0 = 1 and data bits 3:0 not 4'hF changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_i | input | 1 | Chip enable, active high |
| iorq_i | input | 1 | I/O request, active high |
| rd_i | input | 1 | 1 = read cycle, 0 = write cycle |
| m1_i | input | 1 | M1 cycle marker; blocks decode when high |
| port_sel_i | input | 1 | 0 = port A, 1 = port B |
| cd_sel_i | input | 1 | 1 = control, 0 = data |
| data_i | input | 8 | Processor write data |
| data_o | output | 8 | Registered read data |
| data_oe_o | output | 1 | data_o valid / bus drive enable |
| pa_i | input | 8 | Port A pin inputs |
| pa_o | output | 8 | Port A pin drive |
| pb_i | input | 8 | Port B pin inputs |
| pb_o | output | 8 | Port B pin drive |
| int_en_o | output | 2 | Interrupt-enable flags, bit 0 = A, bit 1 = B |
| vec_a_o | output | 8 | Port A interrupt vector |
| vec_b_o | output | 8 | Port B interrupt vector |

## Verification
The hardest state to reach is the pending mask byte. Its value is only seen through the pin drive in bit-control mode, and a mask byte that looks like a mode word or a vector word must not be decoded as one. The bench therefore sweeps all 256 mask values. For each one it writes a bit-control mode word, then the mask, then an output byte, and compares the pins with the mixed value it computes itself. It also sends mask bytes of 0x0F and 0x00 on purpose, then checks that the mode, vector and enable flag kept their values.

// File: rtl/pio_pkg.sv
package pio_pkg;
  typedef enum logic [1:0] {
    MODE_OUT    = 2'd0,
    MODE_IN     = 2'd1,
    MODE_BIDIR  = 2'd2,
    MODE_BITCTL = 2'd3
  } pio_mode_e;

  typedef struct packed {
    logic rd_ctrl;
    logic wr_ctrl;
    logic rd_data;
    logic wr_data;
  } pio_cmd_t;
endpackage

// File: rtl/pio_bus_decode.sv
module pio_bus_decode
  import pio_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     ce_i,
  input  logic     iorq_i,
  input  logic     rd_i,
  input  logic     m1_i,
  input  logic     cd_sel_i,
  output pio_cmd_t cmd_o
);
  logic access;

  assign access        = ce_i & iorq_i & ~m1_i;
  assign cmd_o.rd_ctrl = access &  rd_i &  cd_sel_i;
  assign cmd_o.wr_ctrl = access & ~rd_i &  cd_sel_i;
  assign cmd_o.rd_data = access &  rd_i & ~cd_sel_i;
  assign cmd_o.wr_data = access & ~rd_i & ~cd_sel_i;

  a_r8_one_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cmd_o.rd_ctrl, cmd_o.wr_ctrl, cmd_o.rd_data, cmd_o.wr_data}));
  a_r8_m1_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m1_i || !ce_i || !iorq_i) |-> (cmd_o == '0));
endmodule

// File: rtl/pio_port_regs.sv
module pio_port_regs
  import pio_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_ctrl_i,
  input  logic          wr_data_i,
  input  logic [DW-1:0] data_i,
  output pio_mode_e     mode_o,
  output logic [DW-1:0] out_o,
  output logic [DW-1:0] io_sel_o,
  output logic [DW-1:0] vec_o,
  output logic          int_en_o
);
  localparam logic [3:0] MODE_TAG = 4'hF;

  logic      mask_pend_q;
  logic      is_mode_word;
  pio_mode_e new_mode;

  assign is_mode_word = (data_i[3:0] == MODE_TAG);
  assign new_mode     = pio_mode_e'(data_i[DW-1 -: 2]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o      <= MODE_IN;
      out_o       <= '0;
      io_sel_o    <= '1;
      vec_o       <= '0;
      int_en_o    <= 1'b0;
      mask_pend_q <= 1'b0;
    end else begin
      if (wr_data_i) out_o <= data_i;
      if (wr_ctrl_i) begin
        if (mask_pend_q) begin
          io_sel_o    <= data_i;
          mask_pend_q <= 1'b0;
        end else if (is_mode_word) begin
          mode_o      <= new_mode;
          mask_pend_q <= (new_mode == MODE_BITCTL);
        end else if (!data_i[0]) begin
          vec_o    <= data_i;
          int_en_o <= 1'b1;
        end
      end
    end
  end

  a_r4_vector_enables: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctrl_i && !mask_pend_q && !data_i[0]) |=> (int_en_o && vec_o == $past(data_i)));
  a_r5_data_stored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_data_i |=> (out_o == $past(data_i)));
  a_r9_mask_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctrl_i && !mask_pend_q && is_mode_word && new_mode == MODE_BITCTL) |=> mask_pend_q);
  a_r9_mask_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctrl_i && mask_pend_q) |=> (io_sel_o == $past(data_i) && $stable(mode_o) && $stable(vec_o)));
  a_r8_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_ctrl_i || wr_data_i) |=> ($stable(mode_o) && $stable(out_o) && $stable(io_sel_o)
                                   && $stable(vec_o) && $stable(int_en_o)));
endmodule

// File: rtl/pio_pin_drive.sv
module pio_pin_drive
  import pio_pkg::*;
#(
  parameter int DW = 8
) (
  input  pio_mode_e     mode_i,
  input  logic [DW-1:0] out_i,
  input  logic [DW-1:0] io_sel_i,
  output logic [DW-1:0] pins_o
);
  always_comb begin
    unique case (mode_i)
      MODE_OUT:    pins_o = out_i;
      MODE_BITCTL: pins_o = io_sel_i | (out_i & ~io_sel_i);
      default:     pins_o = '1;
    endcase
  end
endmodule

// File: rtl/pio_dual_port.sv
module pio_dual_port
  import pio_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_i,
  input  logic          iorq_i,
  input  logic          rd_i,
  input  logic          m1_i,
  input  logic          port_sel_i,
  input  logic          cd_sel_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o,
  input  logic [DW-1:0] pa_i,
  output logic [DW-1:0] pa_o,
  input  logic [DW-1:0] pb_i,
  output logic [DW-1:0] pb_o,
  output logic [1:0]    int_en_o,
  output logic [DW-1:0] vec_a_o,
  output logic [DW-1:0] vec_b_o
);
  localparam int NP   = 2;
  localparam int PADW = DW - 3;

  pio_cmd_t                cmd;
  pio_mode_e               mode [NP];
  logic [NP-1:0][DW-1:0]   out_r;
  logic [NP-1:0][DW-1:0]   io_sel;
  logic [NP-1:0][DW-1:0]   vec;
  logic [NP-1:0][DW-1:0]   pin_drv;
  logic [NP-1:0][DW-1:0]   pin_in;
  logic [NP-1:0]           int_en;
  logic [DW-1:0]           rd_mux;

  pio_bus_decode i_decode (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ce_i    (ce_i),
    .iorq_i  (iorq_i),
    .rd_i    (rd_i),
    .m1_i    (m1_i),
    .cd_sel_i(cd_sel_i),
    .cmd_o   (cmd)
  );

  for (genvar g = 0; g < NP; g++) begin : g_port
    logic hit;
    assign hit = (port_sel_i == g[0]);

    pio_port_regs #(.DW(DW)) i_regs (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_ctrl_i(cmd.wr_ctrl & hit),
      .wr_data_i(cmd.wr_data & hit),
      .data_i   (data_i),
      .mode_o   (mode[g]),
      .out_o    (out_r[g]),
      .io_sel_o (io_sel[g]),
      .vec_o    (vec[g]),
      .int_en_o (int_en[g])
    );

    pio_pin_drive #(.DW(DW)) i_drive (
      .mode_i  (mode[g]),
      .out_i   (out_r[g]),
      .io_sel_i(io_sel[g]),
      .pins_o  (pin_drv[g])
    );
  end

  assign pin_in[0] = pa_i;
  assign pin_in[1] = pb_i;
  assign pa_o      = pin_drv[0];
  assign pb_o      = pin_drv[1];
  assign vec_a_o   = vec[0];
  assign vec_b_o   = vec[1];
  assign int_en_o  = int_en;

  always_comb begin
    if (cmd.rd_ctrl) rd_mux = {mode[port_sel_i], {PADW{1'b0}}, int_en[port_sel_i]};
    else             rd_mux = pin_in[port_sel_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o    <= '0;
      data_oe_o <= 1'b0;
    end else begin
      data_oe_o <= cmd.rd_ctrl | cmd.rd_data;
      if (cmd.rd_ctrl | cmd.rd_data) data_o <= rd_mux;
    end
  end

  a_r10_read_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd.rd_data && !port_sel_i) |=> (data_oe_o && data_o == $past(pa_i)));
  a_r10_read_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd.rd_data && port_sel_i) |=> (data_oe_o && data_o == $past(pb_i)));
  a_r8_no_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ce_i && iorq_i && !m1_i) |=> !data_oe_o);
endmodule

// File: tb/test_pio_dual_port.sv
module test_pio_dual_port;
  logic       clk = 0, rst_n = 0;
  logic       ce = 0, iorq = 0, rd = 0, m1 = 0, psel = 0, cd = 0;
  logic [7:0] din = 0, pa_in = 0, pb_in = 0;
  logic [7:0] dout, pa, pb, va, vb;
  logic       doe;
  logic [1:0] ien;
  int         n_chk = 0, n_fail = 0;

  logic [1:0] m_mode [2];
  logic [7:0] m_out [2], m_sel [2], m_vec [2];
  logic       m_ie [2], m_pend [2];

  always #10 clk = ~clk;

  pio_dual_port i_pio_dual_port (
    .clk_i(clk), .rst_ni(rst_n), .ce_i(ce), .iorq_i(iorq), .rd_i(rd), .m1_i(m1),
    .port_sel_i(psel), .cd_sel_i(cd), .data_i(din), .data_o(dout), .data_oe_o(doe),
    .pa_i(pa_in), .pa_o(pa), .pb_i(pb_in), .pb_o(pb), .int_en_o(ien),
    .vec_a_o(va), .vec_b_o(vb)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_pins(input int p);
    case (m_mode[p])
      2'd0:    return m_out[p];
      2'd3:    return m_sel[p] | (m_out[p] & ~m_sel[p]);
      default: return 8'hFF;
    endcase
  endfunction

  task automatic check_state(input string req);
    chk(pa == exp_pins(0), req, pa, exp_pins(0));
    chk(pb == exp_pins(1), req, pb, exp_pins(1));
    chk(ien == {m_ie[1], m_ie[0]}, req, ien, {m_ie[1], m_ie[0]});
    chk(va == m_vec[0] && vb == m_vec[1], req, {va, vb}, {m_vec[0], m_vec[1]});
  endtask

  task automatic raw(input logic c, i, r, m, s, k, input logic [7:0] d);
    @(negedge clk);
    ce = c; iorq = i; rd = r; m1 = m; psel = s; cd = k; din = d;
    @(negedge clk);
    ce = 0; iorq = 0; rd = 0; m1 = 0;
  endtask

  task automatic ctrl_wr(input int p, input logic [7:0] d);
    raw(1, 1, 0, 0, p[0], 1, d);
    if (m_pend[p]) begin
      m_sel[p] = d; m_pend[p] = 0;
    end else if (d[3:0] == 4'hF) begin
      m_mode[p] = d[7:6]; m_pend[p] = (d[7:6] == 2'd3);
    end else if (!d[0]) begin
      m_vec[p] = d; m_ie[p] = 1;
    end
  endtask

  task automatic data_wr(input int p, input logic [7:0] d);
    raw(1, 1, 0, 0, p[0], 0, d);
    m_out[p] = d;
  endtask

  task automatic ctrl_rd_chk(input int p, input string req);
    logic [7:0] e;
    raw(1, 1, 1, 0, p[0], 1, 8'h00);
    e = {m_mode[p], 5'b0, m_ie[p]};
    chk(doe && dout == e, req, {doe, dout}, {1'b1, e});
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int p = 0; p < 2; p++) begin
      m_mode[p] = 2'd1; m_out[p] = 0; m_sel[p] = 8'hFF; m_vec[p] = 0;
      m_ie[p] = 0; m_pend[p] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check_state("R1");
    chk(doe == 0, "R1 oe", doe, 0);
    ctrl_rd_chk(0, "R1 R11 ctrl read A");
    ctrl_rd_chk(1, "R1 R11 ctrl read B");

    // R4 vectors; R2 other port untouched
    ctrl_wr(0, 8'hEE); check_state("R4 R2 vector A");
    ctrl_wr(1, 8'hCC); check_state("R4 R2 vector B");
    ctrl_rd_chk(0, "R11 ie A");

    // R3 R6 R5 mode sweep on each port
    for (int p = 0; p < 2; p++)
      for (int m = 0; m < 3; m++) begin
        ctrl_wr(p, 8'(m << 6) | 8'h0F); check_state("R3 R6 mode");
        data_wr(p, 8'(8'h3C + m * 17 + p)); check_state("R5 R6 data");
        ctrl_rd_chk(p, "R11 R3 mode readback");
      end

    // R5 R2 full output sweep on A while B is input
    ctrl_wr(0, 8'h0F);
    ctrl_wr(1, 8'h4F);
    for (int v = 0; v < 256; v++) begin
      data_wr(0, 8'(v)); check_state("R5 R2 out sweep");
    end
    for (int v = 0; v < 256; v += 7) begin
      data_wr(1, 8'(v)); check_state("R6 R2 B input hides out");
    end

    // R7 R9 bit-control mask sweep
    for (int k = 0; k < 256; k++) begin
      ctrl_wr(0, 8'hFF);
      ctrl_wr(0, 8'(k));
      data_wr(0, ~8'(k) ^ 8'h3C);
      check_state("R7 R9 bitctl mix");
    end
    ctrl_wr(1, 8'hFF); ctrl_wr(1, 8'h0F);
    data_wr(1, 8'hA5); check_state("R9 mask looks like mode word");
    ctrl_rd_chk(1, "R9 mode kept bitctl");
    ctrl_wr(1, 8'hFF); ctrl_wr(1, 8'h00);
    data_wr(1, 8'h5A); check_state("R9 mask looks like vector word");
    ctrl_wr(1, 8'h22); check_state("R9 decode resumes after mask");

    // R10 data read sweeps
    for (int v = 0; v < 256; v++) begin
      pa_in = 8'(v); pb_in = ~8'(v);
      raw(1, 1, 1, 0, 0, 0, 8'h00);
      chk(doe && dout == 8'(v), "R10 read A", {doe, dout}, {1'b1, 8'(v)});
      raw(1, 1, 1, 0, 1, 0, 8'h00);
      chk(doe && dout == ~8'(v), "R10 read B", {doe, dout}, {1'b1, ~8'(v)});
      @(negedge clk);
      chk(doe == 0, "R10 oe one cycle", doe, 0);
    end

    // R8 unmatched cycles
    ctrl_wr(0, 8'h0F); data_wr(0, 8'h11);
    raw(1, 1, 0, 1, 0, 0, 8'h77); check_state("R8 m1 data write");
    raw(0, 1, 0, 0, 0, 0, 8'h77); check_state("R8 no ce");
    raw(1, 0, 0, 0, 0, 0, 8'h77); check_state("R8 no iorq");
    raw(1, 1, 0, 1, 0, 1, 8'h4F); check_state("R8 m1 ctrl write");
    raw(1, 0, 0, 0, 1, 1, 8'h10); check_state("R8 no iorq vector");
    raw(1, 1, 1, 1, 0, 0, 8'h00);
    chk(doe == 0, "R8 m1 read no oe", doe, 0);
    ctrl_rd_chk(0, "R8 mode kept");

    // R12 ignored control words
    ctrl_wr(0, 8'h03); check_state("R12 ignored 03");
    ctrl_wr(1, 8'h87); check_state("R12 ignored 87");
    ctrl_rd_chk(0, "R12 A unchanged");
    ctrl_rd_chk(1, "R12 B unchanged");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule